// File: doc/BRIEF.md
# Timer Channel Input Capture

This block is one channel of a timer. It watches a single input that has already passed an external glitch filter. When that input makes a qualifying transition, the channel stores the current value of a free-running counter bus in a capture register and raises a sticky flag. The block has no counters of its own. Two counter buses come in from outside: one internal to the timer and one external to it. A two-bit select field picks which of the two is the time base.

Two configuration bits decide which transitions count:
- When `both_edge_i` is high, every transition counts and the polarity bit has no effect.
- When `both_edge_i` is low, `pol_i` chooses rising edges only (1) or falling edges only (0).

The input first passes through a synchronizer inside the block. Edges are found by comparing the synchronized level with a one-cycle delayed copy of it.

Software reaches the channel through a small read/write port. The capture word is read-only. The status word holds the flag, which software clears by writing 1 to bit 0. The same flag also drives an output pin, which can serve as an event line.

Top module: `tc_cap_chan`

## Requirements
- R1: After reset, `flag_o` is 0 and both the capture word (address 0) and the status word (address 1) read as 0.
- R2: With `both_edge_i`=0 and `pol_i`=1, a rising input transition causes a capture and a falling one does not.
- R3: With `both_edge_i`=0 and `pol_i`=0, a falling input transition causes a capture and a rising one does not.
- R4: With `both_edge_i`=1, every input transition causes a capture, whatever value `pol_i` holds.
- R5: A capture stores the value the selected counter bus holds at the third rising clock edge after the input changes. `flag_o` rises after that same edge and not earlier.
- R6: `bus_sel_i`=2'b11 selects `cnt_int_i`. The values 2'b00, 2'b01 and 2'b10 select `cnt_ext_i`.
- R7: Once set, the flag stays set until a write to address 1 with `reg_wdata_i`=1 clears it. A write of 0 to address 1 leaves it set.
- R8: If a capture and a flag clear happen in the same cycle, the flag ends up set and the capture register takes the new value.
- R9: A read at address 0 returns the capture register. A read at address 1 returns the flag in bit 0, with every other bit 0. Writes to address 0 change nothing.
- R10: While `cap_en_i` is 0, input transitions neither capture nor set the flag. Raising `cap_en_i` while the input is steady produces no capture.
- R11: Each new capture overwrites the previous captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sig_i | input | 1 | Filtered input signal whose edges are captured |
| cnt_int_i | input | CNT_W | Counter bus internal to the timer |
| cnt_ext_i | input | CNT_W | Counter bus external to the timer |
| bus_sel_i | input | 2 | Time base select; 2'b11 selects the internal bus |
| cap_en_i | input | 1 | Capture mode enable |
| both_edge_i | input | 1 | 1 = capture on every transition |
| pol_i | input | 1 | Edge polarity when both_edge_i is 0 (1 = rising) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address: 0 = capture word, 1 = status word |
| reg_wdata_i | input | 1 | Write data for status bit 0 (1 clears the flag) |
| reg_rdata_o | output | CNT_W | Read data for the addressed word |
| flag_o | output | 1 | Sticky capture flag |

## Verification
The flag's set path (a capture) and its clear path (a software write of 1) can land in the same clock cycle.

The bench provokes this collision by counting the synchronizer latency:
1. It changes the input.
2. On the falling clock edge just before the capture edge, it raises the clear write.
3. It drops that write one cycle later.

The flag was already set before the collision. The bench then checks that the flag still reads 1 and that the capture word holds the counter value of the colliding edge. Finally, a clear on its own must bring the flag to 0.

// File: rtl/tc_cap_pkg.sv
package tc_cap_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  localparam logic [1:0] BUS_SEL_INT = 2'b11;
  localparam logic       ADDR_CAP    = 1'b0;
  localparam logic       ADDR_STAT   = 1'b1;

endpackage

// File: rtl/tc_cap_edge.sv
module tc_cap_edge
  import tc_cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sig_i,
  output edge_t edge_o
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         last_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    logic d;
    if (g == 0) begin : g_first
      assign d = sig_i;
    end else begin : g_rest
      assign d = sync_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[MSB];
  end

  assign edge_o.rise = sync_q[MSB] & ~last_q;
  assign edge_o.fall = ~sync_q[MSB] & last_q;

endmodule

// File: rtl/tc_cap_bus_mux.sv
module tc_cap_bus_mux
  import tc_cap_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic [CNT_W-1:0] cnt_int_i,
  input  logic [CNT_W-1:0] cnt_ext_i,
  input  logic [1:0]       bus_sel_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_comb begin
    if (bus_sel_i == BUS_SEL_INT) cnt_o = cnt_int_i;
    else                          cnt_o = cnt_ext_i;
  end

endmodule

// File: rtl/tc_cap_store.sv
module tc_cap_store #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_evt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o
);

  logic [CNT_W-1:0] cap_q;
  logic             flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cap_q <= '0;
    else if (cap_evt_i) cap_q <= cnt_i;
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (cap_evt_i) flag_q <= 1'b1;
    else if (clr_i)     flag_q <= 1'b0;
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/tc_cap_chan.sv
module tc_cap_chan
  import tc_cap_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_i,
  input  logic [CNT_W-1:0] cnt_int_i,
  input  logic [CNT_W-1:0] cnt_ext_i,
  input  logic [1:0]       bus_sel_i,
  input  logic             cap_en_i,
  input  logic             both_edge_i,
  input  logic             pol_i,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic             reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic             flag_o
);

  edge_t            edge_s;
  logic [CNT_W-1:0] sel_cnt;
  logic [CNT_W-1:0] cap_q;
  logic             cap_evt;
  logic             clr_req;
  logic             edge_hit;

  tc_cap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig_i),
    .edge_o (edge_s)
  );

  tc_cap_bus_mux #(.CNT_W(CNT_W)) u_mux (
    .cnt_int_i (cnt_int_i),
    .cnt_ext_i (cnt_ext_i),
    .bus_sel_i (bus_sel_i),
    .cnt_o     (sel_cnt)
  );

  always_comb begin
    if (both_edge_i) edge_hit = edge_s.rise | edge_s.fall;
    else if (pol_i)  edge_hit = edge_s.rise;
    else             edge_hit = edge_s.fall;
  end

  assign cap_evt = cap_en_i & edge_hit;
  assign clr_req = reg_we_i & (reg_addr_i == ADDR_STAT) & reg_wdata_i;

  tc_cap_store #(.CNT_W(CNT_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_evt_i (cap_evt),
    .cnt_i     (sel_cnt),
    .clr_i     (clr_req),
    .cap_o     (cap_q),
    .flag_o    (flag_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_CAP) reg_rdata_o = cap_q;
    else                        reg_rdata_o[0] = flag_o;
  end

endmodule

// File: rtl/tc_cap_chk.sv
module tc_cap_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cap_evt,
  input logic             clr_req,
  input logic             cap_en_i,
  input logic             flag_o,
  input logic [CNT_W-1:0] cap_q,
  input logic [CNT_W-1:0] sel_cnt
);

  assert_flag_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(cap_evt));

  assert_cap_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> (cap_q == $past(sel_cnt)));

  assert_flag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_req) |=> flag_o);

  assert_flag_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req && !cap_evt) |=> !flag_o);

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt && clr_req) |=> flag_o);

  assert_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> ($stable(cap_q) && !$rose(flag_o)));

endmodule

bind tc_cap_chan tc_cap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cap_evt  (cap_evt),
  .clr_req  (clr_req),
  .cap_en_i (cap_en_i),
  .flag_o   (flag_o),
  .cap_q    (cap_q),
  .sel_cnt  (sel_cnt)
);

// File: tb/tb_tc_cap_chan.sv
module tb_tc_cap_chan;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 24;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             sig_i = 1'b0;
  logic [CNT_W-1:0] cnt_int_i = '0;
  logic [CNT_W-1:0] cnt_ext_i = '0;
  logic [1:0]       bus_sel_i = 2'b11;
  logic             cap_en_i = 1'b1;
  logic             both_edge_i = 1'b0;
  logic             pol_i = 1'b1;
  logic             reg_we_i = 1'b0;
  logic             reg_addr_i = 1'b0;
  logic             reg_wdata_i = 1'b0;
  logic [CNT_W-1:0] reg_rdata_o;
  logic             flag_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tc_cap_chan #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sig_i(sig_i),
    .cnt_int_i(cnt_int_i), .cnt_ext_i(cnt_ext_i), .bus_sel_i(bus_sel_i),
    .cap_en_i(cap_en_i), .both_edge_i(both_edge_i), .pol_i(pol_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .flag_o(flag_o)
  );

  task automatic chk(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [CNT_W-1:0] v);
    reg_addr_i = a;
    #1;
    v = reg_rdata_o;
  endtask

  task automatic wr(input logic a, input logic d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = 1'b0;
  endtask

  // change input at a negedge, then wait past the capture edge
  task automatic drive_sig(input logic v);
    @(negedge clk);
    sig_i = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_cap(input string req, input logic [CNT_W-1:0] exp_cap, input logic exp_flag);
    logic [CNT_W-1:0] v;
    rd(1'b0, v);
    chk(req, v, exp_cap);
    chk(req, {{(CNT_W-1){1'b0}}, flag_o}, {{(CNT_W-1){1'b0}}, exp_flag});
  endtask

  task automatic t_reset;
    logic [CNT_W-1:0] v;
    @(negedge clk);
    chk("R1 flag", {{(CNT_W-1){1'b0}}, flag_o}, '0);
    rd(1'b0, v); chk("R1 cap word", v, '0);
    rd(1'b1, v); chk("R1 status word", v, '0);
  endtask

  task automatic t_rising;
    both_edge_i = 0; pol_i = 1; bus_sel_i = 2'b11;
    cnt_int_i = 24'h001000;
    drive_sig(1'b1);
    chk_cap("R2 rise captures", 24'h001000, 1'b1);
    wr(1'b1, 1'b1);
    cnt_int_i = 24'h002000;
    drive_sig(1'b0);
    chk_cap("R2 fall ignored", 24'h001000, 1'b0);
  endtask

  task automatic t_falling;
    both_edge_i = 0; pol_i = 0;
    cnt_int_i = 24'h003000;
    drive_sig(1'b1);
    chk_cap("R3 rise ignored", 24'h001000, 1'b0);
    cnt_int_i = 24'h003100;
    drive_sig(1'b0);
    chk_cap("R3 fall captures", 24'h003100, 1'b1);
    wr(1'b1, 1'b1);
  endtask

  task automatic t_both;
    both_edge_i = 1; pol_i = 1;
    cnt_int_i = 24'h004000;
    drive_sig(1'b1);
    chk_cap("R4 rise pol1", 24'h004000, 1'b1);
    cnt_int_i = 24'h004001;
    drive_sig(1'b0);
    chk_cap("R4 R11 fall pol1 overwrite", 24'h004001, 1'b1);
    pol_i = 0;
    cnt_int_i = 24'h004002;
    drive_sig(1'b1);
    chk_cap("R4 rise pol0", 24'h004002, 1'b1);
    wr(1'b1, 1'b1);
  endtask

  task automatic t_bus;
    logic v;
    both_edge_i = 1;
    cnt_int_i = 24'h555555; cnt_ext_i = 24'haaaaaa;
    v = sig_i;
    for (int s = 0; s < 4; s++) begin
      bus_sel_i = s[1:0];
      v = ~v;
      drive_sig(v);
      chk_cap("R6 bus select", (s == 3) ? 24'h555555 : 24'haaaaaa, 1'b1);
    end
    wr(1'b1, 1'b1);
  endtask

  task automatic t_latency;
    logic [CNT_W-1:0] v;
    both_edge_i = 1; bus_sel_i = 2'b11;
    @(negedge clk);
    sig_i = ~sig_i;
    cnt_int_i = 24'h006000;
    @(negedge clk); cnt_int_i = cnt_int_i + 1;
    @(negedge clk); cnt_int_i = cnt_int_i + 1;
    chk("R5 flag not early", {{(CNT_W-1){1'b0}}, flag_o}, '0);
    @(negedge clk); cnt_int_i = cnt_int_i + 1;
    chk("R5 flag after third edge", {{(CNT_W-1){1'b0}}, flag_o}, 24'h1);
    rd(1'b0, v);
    chk("R5 value at third edge", v, 24'h006002);
  endtask

  task automatic t_flag;
    logic [CNT_W-1:0] v;
    wr(1'b1, 1'b0);
    chk("R7 write 0 keeps flag", {{(CNT_W-1){1'b0}}, flag_o}, 24'h1);
    rd(1'b1, v);
    chk("R9 status word", v, 24'h1);
    wr(1'b0, 1'b1);
    chk_cap("R9 write cap ignored", 24'h006002, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 flag sticky", {{(CNT_W-1){1'b0}}, flag_o}, 24'h1);
    wr(1'b1, 1'b1);
    chk("R7 clear", {{(CNT_W-1){1'b0}}, flag_o}, '0);
  endtask

  task automatic t_race;
    both_edge_i = 1;
    cnt_int_i = 24'h007100;
    drive_sig(~sig_i);
    chk("R8 precondition", {{(CNT_W-1){1'b0}}, flag_o}, 24'h1);
    cnt_int_i = 24'h007200;
    @(negedge clk); sig_i = ~sig_i;
    @(negedge clk);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = 1'b1; reg_wdata_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = 1'b0;
    chk_cap("R8 capture wins", 24'h007200, 1'b1);
    wr(1'b1, 1'b1);
    chk("R8 later clear", {{(CNT_W-1){1'b0}}, flag_o}, '0);
  endtask

  task automatic t_disable;
    both_edge_i = 1;
    cap_en_i = 0;
    cnt_int_i = 24'h007777;
    drive_sig(~sig_i);
    chk_cap("R10 disabled", 24'h007200, 1'b0);
    @(negedge clk); cap_en_i = 1;
    repeat (4) @(negedge clk);
    chk_cap("R10 enable no spurious", 24'h007200, 1'b0);
    cnt_int_i = 24'h008000;
    drive_sig(~sig_i);
    chk_cap("R10 enabled captures", 24'h008000, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_rising();
    t_falling();
    t_both();
    t_bus();
    t_latency();
    t_flag();
    t_race();
    t_disable();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1: act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule